// File: doc/BRIEF.md
# Block-Transfer DMA Slot Sequencer

This block decides, bus cycle by bus cycle, what a four-channel block-transfer engine does with the shared memory bus. Three of the channels are sources (A, B, C) and one is a destination (D). A start pulse captures three things: the channel-enable field of a control word, a fill-mode flag and a word count. From then on the block presents one slot code per executed cycle. The code names either a channel access or one of three kinds of idle cycle.

The slot pattern for each word is built from the enabled channels:
- A leading position, which is channel A or a waiting idle.
- An optional B position.
- A C position. In fill mode this position is always present, and it becomes a real idle when C is off.
- A trailing position, which is D or an idle.

The destination lags one word behind the sources. For that reason the first word carries no D write, and one extra idle-then-D pair closes the job. Every slot except a real idle needs a free bus cycle. While the bus is taken, the sequencer holds its place and counts missed cycles.

Address generation, the shift and logic datapath, and the fill operation itself sit outside this block. They follow the slot codes it emits.

Top module: `blt_slot_seq`

## Requirements
- R1: Slot codes are SL_NONE=0, A=1, B=2, C=3, D=4, HOLD (idle that claims the bus)=5, WAIT (idle that needs a free bus but claims nothing)=6, REAL (idle that needs no bus)=7. When not busy, slot_code is 0 and bus_req and done are low.
- R2: Outside fill mode, the steady word pattern is, in order:
  - A if enabled, else WAIT;
  - B if enabled;
  - C if enabled;
  - D if enabled, else HOLD when A is enabled, else WAIT.
- R3: In fill mode the C position is always present. It holds C when C is enabled and REAL otherwise. All other positions are the same as in R2.
- R4: The first word uses the steady pattern with its D slot replaced by HOLD (A enabled) or WAIT (A disabled).
- R5: When D is enabled, a WAIT slot and then a D slot follow the last word. A job of N words therefore issues exactly N D slots.
- R6: bus_req is high for every slot other than NONE and REAL. When bus_req is high and bus_free is low, the same slot is presented again in the next cycle.
- R7: A REAL slot executes in its cycle whatever the value of bus_free.
- R8: miss_count increases by one for each cycle in which bus_req is high and bus_free low. It saturates at its maximum and is cleared to 0 when a start is accepted.
- R9: done is a single-cycle pulse in the cycle after the last slot executes, with slot_code 0 in that cycle. busy is high from the cycle after start through the done cycle.
- R10: A start pulse while busy is ignored and leaves the running pattern unchanged.
- R11: A start with word_count 0 produces no slots; done pulses in the next cycle.
- R12: The channel enables are taken from ctrl_word bits 11..8 (A=bit 11, B=bit 10, C=bit 9, D=bit 8). All other ctrl_word bits have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted when not busy |
| ctrl_word | input | CTRL_W | Control word; bits 11..8 enable channels A, B, C, D |
| fill_mode | input | 1 | Fill-mode flag, captured at start |
| word_count | input | WORD_W | Number of words in the job, captured at start |
| bus_free | input | 1 | The current bus cycle is available to this block |
| busy | output | 1 | Job in progress |
| slot_code | output | 3 | Slot presented this cycle |
| bus_req | output | 1 | The presented slot needs the bus |
| done | output | 1 | One-cycle end-of-job pulse |
| miss_count | output | MISS_W | Stalled cycles since the last accepted start |

## Verification
The assertions take for granted the following:
- bus_free is a clean synchronous level, sampled at the same edge as the slot it grants.
- start is a single-cycle pulse.
- ctrl_word, fill_mode and word_count matter only in the start cycle.

The stimulus drives every input on the falling edge, so none of them changes near the sampling edge. It holds bus_free high except in the dedicated stall sequences. It raises start while busy only in the one test built to show that such a pulse is ignored. Job lengths stay small, so miss_count never nears saturation in the runs.

// File: rtl/blt_seq_pkg.sv
package blt_seq_pkg;

    localparam int SLOT_POS = 4;
    localparam int IDX_W    = 2;
    localparam int LEN_W    = 3;

    typedef enum logic [2:0] {
        SL_NONE = 3'd0,
        SL_A    = 3'd1,
        SL_B    = 3'd2,
        SL_C    = 3'd3,
        SL_D    = 3'd4,
        SL_HOLD = 3'd5,
        SL_WAIT = 3'd6,
        SL_REAL = 3'd7
    } slot_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FINAL = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    // mask bits: [3]=A [2]=B [1]=C [0]=D
    function automatic slot_e pos_code(input logic [3:0] m, input int p);
        slot_e r;
        case (p)
            0:       r = m[3] ? SL_A : SL_WAIT;
            1:       r = SL_B;
            2:       r = m[1] ? SL_C : SL_REAL;
            default: r = m[0] ? SL_D : (m[3] ? SL_HOLD : SL_WAIT);
        endcase
        return r;
    endfunction

    function automatic slot_e pat_slot(input logic [3:0] m, input logic f,
                                       input logic [IDX_W-1:0] s);
        logic [SLOT_POS-1:0] en;
        int cnt;
        slot_e r;
        en  = {1'b1, m[1] | f, m[2], 1'b1};
        r   = SL_NONE;
        cnt = 0;
        for (int p = 0; p < SLOT_POS; p++) begin
            if (en[p]) begin
                if (cnt == int'(s)) r = pos_code(m, p);
                cnt++;
            end
        end
        return r;
    endfunction

    function automatic logic [LEN_W-1:0] pat_len(input logic [3:0] m, input logic f);
        return LEN_W'(2) + LEN_W'(m[2]) + LEN_W'(m[1] | f);
    endfunction

    function automatic logic slot_needs_bus(input slot_e c);
        return (c != SL_NONE) && (c != SL_REAL);
    endfunction

endpackage

// File: rtl/blt_slot_rom.sv
module blt_slot_rom
    import blt_seq_pkg::*;
(
    input  logic [3:0]       mask,
    input  logic             fill,
    input  logic [IDX_W-1:0] idx,
    output slot_e            code,
    output logic [LEN_W-1:0] len
);
    slot_e            rom_q [2][16][SLOT_POS];
    logic [LEN_W-1:0] len_q [2][16];

    for (genvar f = 0; f < 2; f++) begin : g_fill
        for (genvar m = 0; m < 16; m++) begin : g_mask
            assign len_q[f][m] = pat_len(4'(m), 1'(f));
            for (genvar s = 0; s < SLOT_POS; s++) begin : g_slot
                assign rom_q[f][m][s] = pat_slot(4'(m), 1'(f), IDX_W'(s));
            end
        end
    end

    assign code = rom_q[fill][mask][idx];
    assign len  = len_q[fill][mask];
endmodule

// File: rtl/blt_miss_ctr.sv
module blt_miss_ctr #(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [MISS_W-1:0] count
);
    localparam logic [MISS_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)                count <= '0;
        else if (inc && count != TOP)  count <= count + 1'b1;
    end
endmodule

// File: rtl/blt_seq_ctrl.sv
module blt_seq_ctrl
    import blt_seq_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [3:0]        mask_in,
    input  logic              fill_in,
    input  logic [WORD_W-1:0] words_in,
    input  logic              bus_free,
    input  slot_e             rom_code,
    input  logic [LEN_W-1:0]  rom_len,
    output logic [3:0]        mask_q,
    output logic              fill_q,
    output logic [IDX_W-1:0]  idx_q,
    output slot_e             cur_code,
    output logic              need_bus,
    output logic              stall,
    output logic              accept,
    output logic              busy,
    output logic              done
);
    seq_state_e        state_q;
    logic [WORD_W-1:0] left_q;
    logic              first_q;
    logic              go;
    logic              last_pos;

    always_comb begin
        cur_code = SL_NONE;
        case (state_q)
            ST_RUN: begin
                cur_code = rom_code;
                if (first_q && rom_code == SL_D)
                    cur_code = mask_q[3] ? SL_HOLD : SL_WAIT;
            end
            ST_FINAL: cur_code = (idx_q == '0) ? SL_WAIT : SL_D;
            default:  cur_code = SL_NONE;
        endcase
    end

    assign need_bus = slot_needs_bus(cur_code);
    assign stall    = need_bus && !bus_free;
    assign go       = (state_q == ST_RUN || state_q == ST_FINAL) && !stall;
    assign last_pos = ({1'b0, idx_q} == rom_len - 1'b1);
    assign accept   = (state_q == ST_IDLE) && start;
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mask_q  <= '0;
            fill_q  <= 1'b0;
            idx_q   <= '0;
            left_q  <= '0;
            first_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        mask_q  <= mask_in;
                        fill_q  <= fill_in;
                        left_q  <= words_in;
                        idx_q   <= '0;
                        first_q <= 1'b1;
                        state_q <= (words_in == '0) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (go) begin
                        if (last_pos) begin
                            idx_q   <= '0;
                            first_q <= 1'b0;
                            if (left_q == WORD_W'(1))
                                state_q <= mask_q[0] ? ST_FINAL : ST_DONE;
                            else
                                left_q <= left_q - 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_FINAL: begin
                    if (go) begin
                        if (idx_q != '0) begin
                            idx_q   <= '0;
                            state_q <= ST_DONE;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blt_slot_seq.sv
module blt_slot_seq
    import blt_seq_pkg::*;
#(
    parameter int CTRL_W = 16,
    parameter int WORD_W = 10,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              fill_mode,
    input  logic [WORD_W-1:0] word_count,
    input  logic              bus_free,
    output logic              busy,
    output logic [2:0]        slot_code,
    output logic              bus_req,
    output logic              done,
    output logic [MISS_W-1:0] miss_count
);
    localparam int MASK_LSB = 8;

    logic [3:0]       mask_sel;
    logic [3:0]       mask_q;
    logic             fill_q;
    logic [IDX_W-1:0] idx_q;
    slot_e            rom_code;
    logic [LEN_W-1:0] rom_len;
    slot_e            cur_code;
    logic             stall;
    logic             accept;
    logic             unused_ctrl_bits;

    assign mask_sel         = ctrl_word[MASK_LSB +: 4];
    assign unused_ctrl_bits = ^{ctrl_word[CTRL_W-1:MASK_LSB+4], ctrl_word[MASK_LSB-1:0]};

    blt_slot_rom u_rom (
        .mask (mask_q),
        .fill (fill_q),
        .idx  (idx_q),
        .code (rom_code),
        .len  (rom_len)
    );

    blt_seq_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .mask_in  (mask_sel),
        .fill_in  (fill_mode),
        .words_in (word_count),
        .bus_free (bus_free),
        .rom_code (rom_code),
        .rom_len  (rom_len),
        .mask_q   (mask_q),
        .fill_q   (fill_q),
        .idx_q    (idx_q),
        .cur_code (cur_code),
        .need_bus (bus_req),
        .stall    (stall),
        .accept   (accept),
        .busy     (busy),
        .done     (done)
    );

    blt_miss_ctr #(.MISS_W(MISS_W)) u_miss (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .inc   (stall),
        .count (miss_count)
    );

    assign slot_code = cur_code;
endmodule

// File: rtl/blt_slot_seq_chk.sv
module blt_slot_seq_chk #(
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_free,
    input logic              busy,
    input logic [2:0]        slot_code,
    input logic              bus_req,
    input logic              done,
    input logic [MISS_W-1:0] miss_count
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (slot_code == 3'd0 && !bus_req && !done));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_free) |=> $stable(slot_code));

    // R7
    real_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_code == 3'd7) |-> !bus_req);

    // R8
    miss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_free && miss_count != '1)
        |=> miss_count == MISS_W'($past(miss_count) + 1'b1));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (slot_code == 3'd0 && busy));
endmodule

bind blt_slot_seq blt_slot_seq_chk #(.MISS_W(MISS_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_free   (bus_free),
    .busy       (busy),
    .slot_code  (slot_code),
    .bus_req    (bus_req),
    .done       (done),
    .miss_count (miss_count)
);

// File: tb/blt_slot_seq_test.sv
`timescale 1ns/1ps
module blt_slot_seq_test;
    localparam int CLK_NS  = 20;
    localparam int WD_CYC  = 200000;
    localparam int NVEC    = 12;
    localparam int WORD_W  = 10;
    localparam int MISS_W  = 16;

    // fields: mask[23:20] fill[19] words[18:15] period[14:12] slots[11:0], slot0 lowest
    localparam logic [23:0] VEC [NVEC] = '{
        {4'hF, 1'b0, 4'd3, 3'd4, {3'd4, 3'd3, 3'd2, 3'd1}},
        {4'hE, 1'b0, 4'd2, 3'd4, {3'd5, 3'd3, 3'd2, 3'd1}},
        {4'h8, 1'b0, 4'd2, 3'd2, {3'd0, 3'd0, 3'd5, 3'd1}},
        {4'h6, 1'b0, 4'd2, 3'd4, {3'd6, 3'd3, 3'd2, 3'd6}},
        {4'h1, 1'b0, 4'd3, 3'd2, {3'd0, 3'd0, 3'd4, 3'd6}},
        {4'h0, 1'b0, 4'd1, 3'd2, {3'd0, 3'd0, 3'd6, 3'd6}},
        {4'hB, 1'b0, 4'd2, 3'd3, {3'd0, 3'd4, 3'd3, 3'd1}},
        {4'h5, 1'b0, 4'd1, 3'd3, {3'd0, 3'd4, 3'd2, 3'd6}},
        {4'hD, 1'b1, 4'd2, 3'd4, {3'd4, 3'd7, 3'd2, 3'd1}},
        {4'h9, 1'b1, 4'd2, 3'd3, {3'd0, 3'd4, 3'd7, 3'd1}},
        {4'h0, 1'b1, 4'd2, 3'd3, {3'd0, 3'd6, 3'd7, 3'd6}},
        {4'h3, 1'b1, 4'd2, 3'd3, {3'd0, 3'd4, 3'd3, 3'd6}}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [15:0]       ctrl_word = '0;
    logic              fill_mode = 1'b0;
    logic [WORD_W-1:0] word_count = '0;
    logic              bus_free = 1'b1;
    logic              busy;
    logic [2:0]        slot_code;
    logic              bus_req;
    logic              done;
    logic [MISS_W-1:0] miss_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int exp_a [64];
    int exp_n;

    always #(CLK_NS/2) clk = ~clk;

    blt_slot_seq uut (
        .clk(clk), .rst(rst), .start(start), .ctrl_word(ctrl_word),
        .fill_mode(fill_mode), .word_count(word_count), .bus_free(bus_free),
        .busy(busy), .slot_code(slot_code), .bus_req(bus_req), .done(done),
        .miss_count(miss_count)
    );

    task automatic chk(input string tag, input int got, input int expv);
        checks++;
        if (got != expv) begin
            errors++;
            $display("FAIL %s: got=%0d expected=%0d at %0t", tag, got, expv, $time);
        end
    endtask

    task automatic launch(input logic [3:0] m, input logic f, input int w);
        @(negedge clk);
        ctrl_word  = {4'hA, m, 8'h5C};   // R12: stray bits around the enable field
        fill_mode  = f;
        word_count = WORD_W'(w);
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        ctrl_word  = 16'hFFFF;
        fill_mode  = ~f;
    endtask

    task automatic run_vec(input int v);
        logic [3:0]  m;
        logic        f;
        int          w, per, dcnt;
        logic [11:0] pat;
        string       tag;
        m   = VEC[v][23:20];
        f   = VEC[v][19];
        w   = int'(VEC[v][18:15]);
        per = int'(VEC[v][14:12]);
        pat = VEC[v][11:0];
        tag = f ? "R3" : "R2";
        exp_n = 0;
        for (int wi = 0; wi < w; wi++) begin
            for (int s = 0; s < per; s++) begin
                int c;
                c = int'(pat[3*s +: 3]);
                if (wi == 0 && c == 4) c = m[3] ? 5 : 6;   // R4
                exp_a[exp_n] = c;
                exp_n++;
            end
        end
        if (m[0]) begin                                  // R5
            exp_a[exp_n] = 6; exp_a[exp_n+1] = 4; exp_n += 2;
        end
        launch(m, f, w);
        dcnt = 0;
        for (int k = 0; k < exp_n; k++) begin
            chk(k < per ? {tag, "/R4"} : (k >= exp_n - 2 && m[0] ? {tag, "/R5"} : tag),
                int'(slot_code), exp_a[k]);
            if (slot_code == 3'd4) dcnt++;
            @(negedge clk);
        end
        chk("R5 d-count", dcnt, m[0] ? w : 0);
        chk("R9 done", int'(done), 1);
        chk("R9 slot at done", int'(slot_code), 0);
        @(negedge clk);
        chk("R9 busy clears", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 slot", int'(slot_code), 0);
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 done", int'(done), 0);
        chk("R8 reset miss", int'(miss_count), 0);

        for (int v = 0; v < NVEC; v++) run_vec(v);

        // R11 zero word count
        launch(4'hF, 1'b0, 0);
        chk("R11 done", int'(done), 1);
        chk("R11 slot", int'(slot_code), 0);
        chk("R11 bus_req", int'(bus_req), 0);
        @(negedge clk);
        chk("R11 idle", int'(busy), 0);

        // R6/R8/R10 stall on mask 8, one word: A then HOLD
        launch(4'h8, 1'b0, 1);
        chk("R6 first slot", int'(slot_code), 1);
        chk("R6 bus_req", int'(bus_req), 1);
        bus_free = 1'b0;
        @(negedge clk);
        chk("R6 held", int'(slot_code), 1);
        ctrl_word = 16'h0F00; start = 1'b1;              // R10 ignored start
        @(negedge clk);
        chk("R6 held", int'(slot_code), 1);
        start = 1'b0;
        @(negedge clk);
        chk("R6 held", int'(slot_code), 1);
        chk("R8 miss count", int'(miss_count), 3);
        bus_free = 1'b1;
        @(negedge clk);
        chk("R10 pattern kept", int'(slot_code), 5);
        @(negedge clk);
        chk("R10 done", int'(done), 1);
        chk("R8 kept after job", int'(miss_count), 3);
        @(negedge clk);
        chk("R10 idle", int'(busy), 0);

        // R7 real idle runs with bus taken; R8 cleared on start
        launch(4'h0, 1'b1, 1);
        chk("R8 cleared", int'(miss_count), 0);
        chk("R7 wait", int'(slot_code), 6);
        @(negedge clk);
        chk("R7 real", int'(slot_code), 7);
        chk("R7 no bus_req", int'(bus_req), 0);
        bus_free = 1'b0;
        @(negedge clk);
        chk("R7 advanced", int'(slot_code), 6);
        @(negedge clk);
        chk("R6 wait stalls", int'(slot_code), 6);
        chk("R8 one miss", int'(miss_count), 1);
        bus_free = 1'b1;
        @(negedge clk);
        chk("R9 done", int'(done), 1);
        @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(longint'(WD_CYC) * CLK_NS);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule